// File: doc/BRIEF.md
# Transmit FIFO with Watermark Request

This block is a word-wide transmit buffer between a DMA-style producer and a peripheral consumer. The producer pushes 32-bit words, and the consumer pops them in order. The buffer keeps its fill level as a byte count, derived from a write pointer and a read pointer that are each one bit wider than the storage address. From that count it drives a request line back to the producer. The request drops once free space shrinks to a programmable watermark and comes back with one word of hysteresis. This leaves room for the writes that a pipelined producer still delivers after the request has fallen.

A small control register holds a 3-bit granularity field, which sets the watermark in 4-byte steps, and one mask bit per error source. Five sticky status flags record abnormal events. Software clears a flag by writing 1 to it. A combined error output is high whenever any unmasked flag is set.

Top module: `tx_wm_fifo`

## Requirements
- R1: Words read out in the order they were written. A write is accepted when the buffer is not full. `rd_data_o` holds the popped word from the clock edge that follows a read. `free_bytes_o` equals 4 times the number of empty word slots (512 when empty at the default depth).
- R2: The registered `req_o` falls at the clock edge where the free byte count seen in the prior cycle is at or below granularity×4. Granularity is control bits [2:0].
- R3: A write while full is discarded and sets the overflow flag, `stat_o[4]`.
- R4: A read while empty sets the underflow flag, `stat_o[3]`, and `rd_data_o` becomes zero at the next edge.
- R5: With `req_o` low, the request reasserts at the edge where the free byte count exceeds granularity×4 + 4.
- R6: With granularity 0, `req_o` stays high until the buffer is completely full.
- R7: While `req_o` is low, the first two accepted writes are tolerated. Each further accepted write sets the late-write flag, `stat_o[2]`. The count restarts when `req_o` is high.
- R8: Every cycle in which granularity is below 4 sets the unsafe-setting flag, `stat_o[1]`.
- R9: A write and a read in the same cycle while the buffer is empty or full (same storage slot) set the slot-clash flag, `stat_o[0]`.
- R10: Flags are sticky. Writing 1 on `stat_clr_i[n]` clears flag n, but a set in the same cycle wins.
- R11: `err_o` is the OR of the flags whose mask is 0. The mask for flag n is control bit 3+n.
- R12: After reset, the control register reads 0x0020 (only the late-write mask set), all flags are 0, `req_o` is 1 and the buffer is empty.
- R13: Control bits [15:8] always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Producer write strobe |
| wr_data_i | input | 32 | Producer write word |
| rd_en_i | input | 1 | Consumer read strobe |
| rd_data_o | output | 32 | Word popped by the last read |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 16 | Control register write value |
| cfg_rdata_o | output | 16 | Control register contents |
| stat_clr_i | input | 5 | Write-1-to-clear strobes for the flags |
| stat_o | output | 5 | Sticky flags {over, under, late, unsafe, clash} |
| err_o | output | 1 | OR of unmasked flags |
| req_o | output | 1 | Data request toward the producer |
| free_bytes_o | output | 10 | Free space in bytes |

## Verification
The bench builds the block at its default depth of 128 words. At that depth, a full fill and a full drain each take about 130 cycles, so the watermark drop, the late writes, overflow at full and reassertion while draining all occur in one short run. Granularity is run at 4 to check the slack after the drop, and at 0 to check that the request holds until full and that the unsafe flag is raised.

// File: rtl/tx_wm_pkg.sv
package tx_wm_pkg;
  localparam int NUM_FLAGS  = 5;
  localparam int GR_W       = 3;
  localparam int SAFE_GR    = 4;
  localparam int LATE_SLACK = 2;
  localparam int CFG_BITS   = GR_W + NUM_FLAGS;

  typedef enum int unsigned {
    FLG_CLASH = 0,
    FLG_GRAN  = 1,
    FLG_LATE  = 2,
    FLG_UNDER = 3,
    FLG_OVER  = 4
  } flag_e;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] mask;
    logic [GR_W-1:0]      gran;
  } cfg_t;

  localparam logic [CFG_BITS-1:0] CFG_RST = 8'h20;
endpackage

// File: rtl/tx_wm_store.sv
module tx_wm_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_req_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW:0]   used_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          wr_acc_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wp_q, rp_q;
  logic          pop;

  assign used_o   = wp_q - rp_q;
  assign full_o   = used_o == (AW+1)'(DEPTH);
  assign empty_o  = used_o == '0;
  assign wr_acc_o = wr_req_i && !full_o;
  assign pop      = rd_req_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (wr_acc_o) mem_q[wp_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (wr_acc_o) wp_q <= wp_q + 1'b1;
      if (pop)      rp_q <= rp_q + 1'b1;
      if (rd_req_i) rdata_o <= pop ? mem_q[rp_q[AW-1:0]] : '0;
    end
  end
endmodule

// File: rtl/tx_wm_req.sv
module tx_wm_req #(
  parameter int FREE_W = 10,
  parameter int GR_W   = 3,
  parameter int SLACK  = 2,
  localparam int LC_W  = $clog2(SLACK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREE_W-1:0] free_i,
  input  logic [GR_W-1:0]   gran_i,
  input  logic              wr_acc_i,
  output logic              req_o,
  output logic              late_o
);
  logic [FREE_W-1:0] wm_lo, wm_hi;
  logic [LC_W-1:0]   late_q;

  assign wm_lo  = FREE_W'({gran_i, 2'b00});
  assign wm_hi  = wm_lo + FREE_W'(4);
  // third and later accepted writes past the drop
  assign late_o = !req_o && wr_acc_i && (late_q == LC_W'(SLACK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b1;
      late_q <= '0;
    end else begin
      if (req_o && free_i <= wm_lo)      req_o <= 1'b0;
      else if (!req_o && free_i > wm_hi) req_o <= 1'b1;
      if (req_o) late_q <= '0;
      else if (wr_acc_i && late_q != LC_W'(SLACK)) late_q <= late_q + 1'b1;
    end
  end
endmodule

// File: rtl/tx_wm_stat.sv
module tx_wm_stat #(
  parameter int NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic [NF-1:0] mask_i,
  output logic [NF-1:0] stat_o,
  output logic          err_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       stat_o[g] <= 1'b0;
      else if (set_i[g]) stat_o[g] <= 1'b1;
      else if (clr_i[g]) stat_o[g] <= 1'b0;
    end
  end

  assign err_o = |(stat_o & ~mask_i);
endmodule

// File: rtl/tx_wm_fifo.sv
module tx_wm_fifo
  import tx_wm_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 128,
  parameter int CTRL_W = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int FREE_W = AW + 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 rd_en_i,
  output logic [DW-1:0]        rd_data_o,
  input  logic                 cfg_we_i,
  input  logic [CTRL_W-1:0]    cfg_wdata_i,
  output logic [CTRL_W-1:0]    cfg_rdata_o,
  input  logic [NUM_FLAGS-1:0] stat_clr_i,
  output logic [NUM_FLAGS-1:0] stat_o,
  output logic                 err_o,
  output logic                 req_o,
  output logic [FREE_W-1:0]    free_bytes_o
);
  cfg_t                 cfg_q;
  logic [AW:0]          used;
  logic                 full, empty, wr_acc, late;
  logic [NUM_FLAGS-1:0] flag_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= cfg_t'(CFG_RST);
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i[CFG_BITS-1:0]);
  end

  assign cfg_rdata_o  = {{(CTRL_W-CFG_BITS){1'b0}}, cfg_q};
  assign free_bytes_o = {(AW+1)'(DEPTH) - used, 2'b00};

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_CLASH] = wr_valid_i && rd_en_i && (empty || full);
    flag_set[FLG_GRAN]  = cfg_q.gran < GR_W'(SAFE_GR);
    flag_set[FLG_LATE]  = late;
    flag_set[FLG_UNDER] = rd_en_i && empty;
    flag_set[FLG_OVER]  = wr_valid_i && full;
  end

  tx_wm_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (wr_valid_i),
    .wdata_i  (wr_data_i),
    .rd_req_i (rd_en_i),
    .rdata_o  (rd_data_o),
    .used_o   (used),
    .full_o   (full),
    .empty_o  (empty),
    .wr_acc_o (wr_acc)
  );

  tx_wm_req #(.FREE_W(FREE_W), .GR_W(GR_W), .SLACK(LATE_SLACK)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .free_i   (free_bytes_o),
    .gran_i   (cfg_q.gran),
    .wr_acc_i (wr_acc),
    .req_o    (req_o),
    .late_o   (late)
  );

  tx_wm_stat #(.NF(NUM_FLAGS)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (stat_clr_i),
    .mask_i (cfg_q.mask),
    .stat_o (stat_o),
    .err_o  (err_o)
  );
endmodule

// File: rtl/tx_wm_fifo_chk.sv
module tx_wm_fifo_chk #(
  parameter int DEPTH = 128,
  localparam int FREE_W = $clog2(DEPTH) + 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              rd_en_i,
  input logic [31:0]       rd_data_o,
  input logic [15:0]       cfg_rdata_o,
  input logic [4:0]        stat_o,
  input logic              err_o,
  input logic              req_o,
  input logic [FREE_W-1:0] free_bytes_o
);
  localparam logic [FREE_W-1:0] ALL_FREE = FREE_W'(DEPTH * 4);
  logic [FREE_W-1:0] wm;
  assign wm = FREE_W'({cfg_rdata_o[2:0], 2'b00});

  p_free_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_bytes_o <= ALL_FREE);
  p_req_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && free_bytes_o <= wm |=> !req_o);
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i && free_bytes_o == '0 |=> stat_o[4] && free_bytes_o == '0);
  p_under_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && free_bytes_o == ALL_FREE |=> stat_o[3] && rd_data_o == '0);
  p_req_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && free_bytes_o > wm + FREE_W'(4) |=> req_o);
  p_gran_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[2:0] < 3'd4 |=> stat_o[1]);
  p_masked_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & ~cfg_rdata_o[7:3]) == '0 |-> !err_o);
endmodule

bind tx_wm_fifo tx_wm_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .rd_en_i      (rd_en_i),
  .rd_data_o    (rd_data_o),
  .cfg_rdata_o  (cfg_rdata_o),
  .stat_o       (stat_o),
  .err_o        (err_o),
  .req_o        (req_o),
  .free_bytes_o (free_bytes_o)
);

// File: tb/sim_tx_wm_fifo.sv
module sim_tx_wm_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic        clk = 0, rst_ni = 0;
  logic        wv = 0, re = 0, cwe = 0;
  logic [31:0] wd = 0;
  logic [15:0] cwd = 0;
  logic [4:0]  clr = 0;
  logic [31:0] rd_data_o;
  logic [15:0] cfg_rdata_o;
  logic [4:0]  stat_o;
  logic        err_o, req_o;
  logic [9:0]  free_bytes_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_wm_fifo u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wv), .wr_data_i(wd),
    .rd_en_i(re), .rd_data_o(rd_data_o), .cfg_we_i(cwe), .cfg_wdata_i(cwd),
    .cfg_rdata_o(cfg_rdata_o), .stat_clr_i(clr), .stat_o(stat_o),
    .err_o(err_o), .req_o(req_o), .free_bytes_o(free_bytes_o)
  );

  // reference model
  logic [31:0] mq[$];
  logic [31:0] m_rd;
  logic [7:0]  m_cfg;
  logic [4:0]  m_stat;
  logic        m_req;
  int          m_late;

  always @(posedge clk or negedge rst_ni) begin
    int cnt, free_pre, wm;
    bit wr_ok;
    logic [4:0] set;
    if (!rst_ni) begin
      mq.delete(); m_rd = 0; m_cfg = 8'h20; m_stat = 0; m_req = 1; m_late = 0;
    end else begin
      cnt = mq.size();
      free_pre = (DEPTH - cnt) * 4;
      wm = int'(m_cfg[2:0]) * 4;
      set = 0;
      wr_ok = wv && cnt < DEPTH;
      if (wv && cnt == DEPTH) set[4] = 1;
      if (wv && re && (cnt == 0 || cnt == DEPTH)) set[0] = 1;
      if (re) begin
        if (cnt == 0) begin set[3] = 1; m_rd = 0; end
        else m_rd = mq.pop_front();
      end
      if (wr_ok) mq.push_back(wd);
      if (m_cfg[2:0] < 3'd4) set[1] = 1;
      if (m_req) m_late = 0;
      else if (wr_ok) begin
        if (m_late == 2) set[2] = 1; else m_late++;
      end
      if (m_req && free_pre <= wm) m_req = 0;
      else if (!m_req && free_pre > wm + 4) m_req = 1;
      m_stat = (m_stat & ~clr) | set;
      if (cwe) m_cfg = cwd[7:0];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    chk(rd_data_o === m_rd, "R1 rd_data vs model", rd_data_o, m_rd);
    chk(free_bytes_o === 10'((DEPTH - mq.size()) * 4), "R1 free_bytes vs model",
        32'(free_bytes_o), 32'((DEPTH - mq.size()) * 4));
    chk(req_o === m_req, "R2 req vs model", 32'(req_o), 32'(m_req));
    chk(stat_o === m_stat, "R10 stat vs model", 32'(stat_o), 32'(m_stat));
    chk(err_o === |(m_stat & ~m_cfg[7:3]), "R11 err vs model", 32'(err_o),
        32'(|(m_stat & ~m_cfg[7:3])));
    chk(cfg_rdata_o === {8'h00, m_cfg}, "R13 cfg vs model", 32'(cfg_rdata_o), 32'(m_cfg));
  end

  task automatic cyc(input bit a_wv, input logic [31:0] a_wd, input bit a_re,
                     input bit a_cwe, input logic [15:0] a_cwd, input logic [4:0] a_clr);
    wv = a_wv; wd = a_wd; re = a_re; cwe = a_cwe; cwd = a_cwd; clr = a_clr;
    @(negedge clk);
    wv = 0; re = 0; cwe = 0; clr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(cfg_rdata_o == 16'h0020, "R12 reset cfg", 32'(cfg_rdata_o), 32'h20);
    chk(stat_o == 0, "R12 reset stat", 32'(stat_o), 0);
    chk(req_o == 1, "R12 reset req", 32'(req_o), 1);
    chk(free_bytes_o == 10'd512, "R12 reset free", 32'(free_bytes_o), 512);
    rst_ni = 1;
    @(negedge clk);
    // gran 4, masks clear, reserved bits written
    cyc(0, 0, 0, 1, 16'hFF04, 5'h1F);
    chk(cfg_rdata_o == 16'h0004, "R13 reserved bits ignored", 32'(cfg_rdata_o), 32'h4);
    cyc(0, 0, 0, 0, 0, 5'h1F);
    chk(stat_o == 0, "R10 clear all", 32'(stat_o), 0);
    // ordering
    for (int i = 0; i < 5; i++) cyc(1, 32'h1234_5600 + i, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1, 0, 0, 0);
      chk(rd_data_o == 32'h1234_5600 + i, "R1 order", rd_data_o, 32'h1234_5600 + i);
    end
    // fill until request drops
    n = 0;
    while (req_o && n < 200) begin cyc(1, 32'hA500_0000 + n, 0, 0, 0, 0); n++; end
    chk(free_bytes_o <= 10'd16, "R2 drop at watermark", 32'(free_bytes_o), 16);
    chk(free_bytes_o == 10'd12, "R2 drop level", 32'(free_bytes_o), 12);
    cyc(1, 32'hA500_0000 + n, 0, 0, 0, 0); n++;
    cyc(1, 32'hA500_0000 + n, 0, 0, 0, 0); n++;
    chk(stat_o[2] == 0, "R7 two late writes tolerated", 32'(stat_o), 0);
    cyc(1, 32'hA500_0000 + n, 0, 0, 0, 0); n++;
    chk(stat_o[2] == 1, "R7 third late write flagged", 32'(stat_o[2]), 1);
    chk(free_bytes_o == 0, "R7 late writes kept", 32'(free_bytes_o), 0);
    cyc(1, 32'hDEAD_BEEF, 0, 0, 0, 0);
    chk(stat_o[4] == 1, "R3 overflow flag", 32'(stat_o[4]), 1);
    chk(free_bytes_o == 0, "R3 overflow discarded", 32'(free_bytes_o), 0);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 1, 0, 0, 0);
      chk(rd_data_o == 32'hA500_0000 + i, "R1 drain order", rd_data_o, 32'hA500_0000 + i);
    end
    chk(req_o == 1, "R5 request back", 32'(req_o), 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk(rd_data_o == 0 && stat_o[3] == 1, "R4 underflow", rd_data_o, 0);
    // clash
    cyc(1, 32'h5A5A_0001, 1, 0, 0, 0);
    chk(stat_o[0] == 1, "R9 slot clash", 32'(stat_o[0]), 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk(rd_data_o == 32'h5A5A_0001, "R9 clash write kept", rd_data_o, 32'h5A5A_0001);
    // gran 0
    cyc(0, 0, 0, 1, 16'h0000, 5'h1F);
    for (int i = 0; i < DEPTH - 1; i++) cyc(1, 32'hC000_0000 + i, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(req_o == 1, "R6 request held at one free word", 32'(req_o), 1);
    chk(stat_o[1] == 1, "R8 unsafe granularity", 32'(stat_o[1]), 1);
    cyc(1, 32'hC000_007F, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    chk(req_o == 0, "R6 request drops when full", 32'(req_o), 0);
    // W1C with set winning
    cyc(0, 0, 0, 0, 0, 5'h1F);
    chk(stat_o == 5'b00010, "R10 set wins over clear", 32'(stat_o), 2);
    // masks
    cyc(0, 0, 0, 1, 16'h00F8, 0);
    chk(err_o == 0, "R11 all masked", 32'(err_o), 0);
    cyc(0, 0, 0, 1, 16'h00E8, 0);
    chk(err_o == 1, "R11 unsafe flag unmasked", 32'(err_o), 1);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 1, 0, 0, 0);
    chk(free_bytes_o == 10'd512, "R1 empty again", 32'(free_bytes_o), 512);
    finish_run();
  end
endmodule